// File: doc/BRIEF.md
# Memory-Side Atomic Read-Modify-Write Unit

This unit sits between a requester and a single-port synchronous word memory. It carries out atomic updates inside the memory system itself, so the requester never has to lock the bus across two transactions. Plain reads and writes go straight to the memory. An atomic read does two things. It returns the word that was stored at the address. On the next cycle it writes a changed value back to the same location. The four changes are: all ones (set), zero (clear), plus one (increment) and minus one (decrement).

A request can be made atomic in two ways. The first is a dedicated 5-bit transaction-type code on a single-beat read. The second is a plain single-beat read whose address falls inside a configurable window. In the second case the window's own operation is applied. Atomic and ordinary reads can be mixed freely on the same memory. The write-back always lands on the cycle right after the read, and no other request can reach the memory between the two.

Top module: `atomic_rmw_unit`

## Requirements
- R1: A request with type code TT_WRITE (default 5'h02) writes `req_wdata` to `req_addr` on its accept cycle and produces no response on the following cycle.
- R2: A request with type code TT_READ (default 5'h0A), outside the atomic window, reads the addressed word. `rsp_valid` is high on the cycle after accept, with `rsp_data` equal to the stored word. The word itself is left unchanged.
- R3: A single-beat request with code TT_SET (default 5'h1A) returns the prior word and then leaves the location holding all ones.
- R4: A single-beat request with code TT_CLR (default 5'h1B) returns the prior word and then leaves the location holding zero.
- R5: A single-beat request with code TT_INC (default 5'h1C) returns the prior word and then stores the prior word plus one, modulo 2^DW. So all ones becomes zero.
- R6: A single-beat request with code TT_DEC (default 5'h1D) returns the prior word and then stores the prior word minus one, modulo 2^DW. So zero becomes all ones.
- R7: On the cycle after an atomic request is accepted, `req_ready` is low. On that cycle the memory port performs a write (`mem_en` and `mem_we` high) to the same address. A request that is held pending is accepted only after that cycle.
- R8: A request with `req_burst` high is never atomic. An atomic code with `req_burst` high behaves as a plain read (R2).
- R9: When the window is enabled, a single-beat TT_READ whose address satisfies `(addr & WIN_MASK) == (WIN_BASE & WIN_MASK)` performs the WIN_OP atomic operation.
- R10: An atomic type code takes priority over the window. An atomic code inside the window performs the code's operation, not WIN_OP.
- R11: During and right after reset, `req_ready` is high, `rsp_valid` is low and `mem_en` is low while no request is offered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Request accepted when high together with req_valid |
| req_type | input | 5 | Transaction-type code |
| req_burst | input | 1 | Request is part of a burst |
| req_addr | input | AW | Word address |
| req_wdata | input | DW | Write data |
| rsp_valid | output | 1 | Read data valid (cycle after a read is accepted) |
| rsp_data | output | DW | Read data (pre-modification value for atomics) |
| mem_en | output | 1 | Memory port enable |
| mem_we | output | 1 | Memory port write enable |
| mem_addr | output | AW | Memory port address |
| mem_wdata | output | DW | Memory port write data |
| mem_rdata | input | DW | Memory read data, one cycle after a read enable |

## Verification
The bench builds the unit with an 8-bit word and a 16-word address space. The increment wrap from 8'hFF and the decrement wrap from 8'h00 therefore occur under random traffic as well as in directed cases. The window is set to addresses 12 to 15 with increment as its operation. This lets plain reads, window reads, and atomic codes inside the window (the priority case) all hit the same few locations. The shared-adder variant is the one selected.

// File: rtl/armw_pkg.sv
package armw_pkg;
   typedef enum logic [2:0] {
      OP_NONE = 3'd0,
      OP_SET  = 3'd1,
      OP_CLR  = 3'd2,
      OP_INC  = 3'd3,
      OP_DEC  = 3'd4
   } armw_op_e;
endpackage

// File: rtl/armw_decode.sv
module armw_decode
   import armw_pkg::*;
#(
   parameter int       AW       = 10,
   parameter int       TW       = 5,
   parameter logic [4:0] TT_WRITE = 5'h02,
   parameter logic [4:0] TT_READ  = 5'h0A,
   parameter logic [4:0] TT_SET   = 5'h1A,
   parameter logic [4:0] TT_CLR   = 5'h1B,
   parameter logic [4:0] TT_INC   = 5'h1C,
   parameter logic [4:0] TT_DEC   = 5'h1D,
   parameter bit       WIN_EN   = 1'b1,
   parameter logic [AW-1:0] WIN_BASE = '1,
   parameter logic [AW-1:0] WIN_MASK = '1,
   parameter armw_op_e WIN_OP   = OP_SET
) (
   input  logic [TW-1:0] type_i,
   input  logic          burst_i,
   input  logic [AW-1:0] addr_i,
   output logic          is_write_o,
   output armw_op_e      op_o
);
   armw_op_e code_op;
   logic     win_hit;

   assign is_write_o = (type_i == TT_WRITE);

   always_comb begin
      code_op = OP_NONE;
      if (!burst_i) begin
         if      (type_i == TT_SET) code_op = OP_SET;
         else if (type_i == TT_CLR) code_op = OP_CLR;
         else if (type_i == TT_INC) code_op = OP_INC;
         else if (type_i == TT_DEC) code_op = OP_DEC;
      end
   end

   generate
      if (WIN_EN) begin : g_win
         assign win_hit = !burst_i && (type_i == TT_READ) &&
                          ((addr_i & WIN_MASK) == (WIN_BASE & WIN_MASK));
      end else begin : g_nowin
         assign win_hit = 1'b0;
      end
   endgenerate

   // explicit code outranks the window
   assign op_o = (code_op != OP_NONE) ? code_op : (win_hit ? WIN_OP : OP_NONE);
endmodule

// File: rtl/armw_modify.sv
module armw_modify
   import armw_pkg::*;
#(
   parameter int DW           = 32,
   parameter bit SHARED_ADDER = 1'b1
) (
   input  armw_op_e      op_i,
   input  logic [DW-1:0] old_i,
   output logic [DW-1:0] new_o
);
   logic [DW-1:0] arith;

   generate
      if (SHARED_ADDER) begin : g_shared
         logic [DW-1:0] step;
         assign step  = (op_i == OP_DEC) ? '1 : DW'(1);
         assign arith = old_i + step;
      end else begin : g_split
         logic [DW-1:0] up, dn;
         assign up    = old_i + DW'(1);
         assign dn    = old_i - DW'(1);
         assign arith = (op_i == OP_DEC) ? dn : up;
      end
   endgenerate

   always_comb begin
      unique case (op_i)
         OP_SET:  new_o = '1;
         OP_CLR:  new_o = '0;
         OP_INC,
         OP_DEC:  new_o = arith;
         default: new_o = old_i;
      endcase
   end
endmodule

// File: rtl/armw_seq.sv
module armw_seq
   import armw_pkg::*;
#(
   parameter int AW = 10,
   parameter int DW = 32
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          req_valid,
   output logic          req_ready,
   input  logic [AW-1:0] req_addr,
   input  logic [DW-1:0] req_wdata,
   input  logic          is_write,
   input  armw_op_e      req_op,
   output armw_op_e      wb_op,
   input  logic [DW-1:0] wb_value,
   output logic          rsp_valid,
   output logic          mem_en,
   output logic          mem_we,
   output logic [AW-1:0] mem_addr,
   output logic [DW-1:0] mem_wdata
);
   logic          wb_pend;
   logic [AW-1:0] wb_addr;
   logic          accept;

   assign req_ready = !wb_pend;
   assign accept    = req_valid && !wb_pend;

   always_comb begin
      mem_en    = 1'b0;
      mem_we    = 1'b0;
      mem_addr  = req_addr;
      mem_wdata = req_wdata;
      if (wb_pend) begin
         mem_en    = 1'b1;
         mem_we    = 1'b1;
         mem_addr  = wb_addr;
         mem_wdata = wb_value;
      end else if (req_valid) begin
         mem_en = 1'b1;
         mem_we = is_write;
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         wb_pend   <= 1'b0;
         wb_addr   <= '0;
         wb_op     <= OP_NONE;
         rsp_valid <= 1'b0;
      end else begin
         wb_pend   <= accept && !is_write && (req_op != OP_NONE);
         rsp_valid <= accept && !is_write;
         if (accept) begin
            wb_addr <= req_addr;
            wb_op   <= is_write ? OP_NONE : req_op;
         end
      end
   end

   AST_WB_BLOCKS_PORT: assert property (@(posedge clk) disable iff (rst)
      wb_pend |-> !req_ready);                                             // R7
   AST_WB_IS_WRITE: assert property (@(posedge clk) disable iff (rst)
      wb_pend |-> (mem_en && mem_we));                                     // R7
   AST_WB_SAME_ADDR: assert property (@(posedge clk) disable iff (rst)
      wb_pend |-> (mem_addr == $past(mem_addr)));                          // R7
   AST_RSP_AFTER_READ: assert property (@(posedge clk) disable iff (rst)
      (mem_en && !mem_we) |=> rsp_valid);                                  // R2
   AST_NO_RSP_AFTER_WRITE: assert property (@(posedge clk) disable iff (rst)
      (mem_en && mem_we) |=> !rsp_valid);                                  // R1
endmodule

// File: rtl/atomic_rmw_unit.sv
module atomic_rmw_unit
   import armw_pkg::*;
#(
   parameter int         AW           = 10,
   parameter int         DW           = 32,
   parameter logic [4:0] TT_WRITE     = 5'h02,
   parameter logic [4:0] TT_READ      = 5'h0A,
   parameter logic [4:0] TT_SET       = 5'h1A,
   parameter logic [4:0] TT_CLR       = 5'h1B,
   parameter logic [4:0] TT_INC       = 5'h1C,
   parameter logic [4:0] TT_DEC       = 5'h1D,
   parameter bit         WIN_EN       = 1'b1,
   parameter logic [AW-1:0] WIN_BASE  = '1,
   parameter logic [AW-1:0] WIN_MASK  = '1,
   parameter armw_op_e   WIN_OP       = OP_SET,
   parameter bit         SHARED_ADDER = 1'b1
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          req_valid,
   output logic          req_ready,
   input  logic [4:0]    req_type,
   input  logic          req_burst,
   input  logic [AW-1:0] req_addr,
   input  logic [DW-1:0] req_wdata,
   output logic          rsp_valid,
   output logic [DW-1:0] rsp_data,
   output logic          mem_en,
   output logic          mem_we,
   output logic [AW-1:0] mem_addr,
   output logic [DW-1:0] mem_wdata,
   input  logic [DW-1:0] mem_rdata
);
   localparam int TW = 5;

   generate
      if (AW < 1 || DW < 1) begin : g_bad_width
         $error("atomic_rmw_unit: AW and DW must be at least 1");
      end
      if (TT_WRITE == TT_READ || TT_SET == TT_READ || TT_SET == TT_WRITE ||
          TT_CLR == TT_SET || TT_INC == TT_SET || TT_DEC == TT_SET ||
          TT_CLR == TT_INC || TT_CLR == TT_DEC || TT_INC == TT_DEC) begin : g_bad_code
         $error("atomic_rmw_unit: transaction codes must be distinct");
      end
      if (WIN_EN && WIN_OP == OP_NONE) begin : g_bad_win
         $error("atomic_rmw_unit: window needs an atomic operation");
      end
   endgenerate

   logic     is_write;
   armw_op_e req_op;
   armw_op_e wb_op;
   logic [DW-1:0] wb_value;

   armw_decode #(
      .AW(AW), .TW(TW),
      .TT_WRITE(TT_WRITE), .TT_READ(TT_READ), .TT_SET(TT_SET),
      .TT_CLR(TT_CLR), .TT_INC(TT_INC), .TT_DEC(TT_DEC),
      .WIN_EN(WIN_EN), .WIN_BASE(WIN_BASE), .WIN_MASK(WIN_MASK), .WIN_OP(WIN_OP)
   ) u_decode (
      .type_i     (req_type),
      .burst_i    (req_burst),
      .addr_i     (req_addr),
      .is_write_o (is_write),
      .op_o       (req_op)
   );

   armw_modify #(.DW(DW), .SHARED_ADDER(SHARED_ADDER)) u_modify (
      .op_i  (wb_op),
      .old_i (mem_rdata),
      .new_o (wb_value)
   );

   armw_seq #(.AW(AW), .DW(DW)) u_seq (
      .clk       (clk),
      .rst       (rst),
      .req_valid (req_valid),
      .req_ready (req_ready),
      .req_addr  (req_addr),
      .req_wdata (req_wdata),
      .is_write  (is_write),
      .req_op    (req_op),
      .wb_op     (wb_op),
      .wb_value  (wb_value),
      .rsp_valid (rsp_valid),
      .mem_en    (mem_en),
      .mem_we    (mem_we),
      .mem_addr  (mem_addr),
      .mem_wdata (mem_wdata)
   );

   assign rsp_data = mem_rdata;
endmodule

// File: tb/atomic_rmw_unit_tb.sv
`timescale 1ns/1ps
module atomic_rmw_unit_tb;
   import armw_pkg::*;
   localparam int AW = 4;
   localparam int DW = 8;
   localparam int NW = 1 << AW;
   localparam logic [4:0] C_WR = 5'h02, C_RD = 5'h0A, C_SET = 5'h1A,
                          C_CLR = 5'h1B, C_INC = 5'h1C, C_DEC = 5'h1D;

   logic          clk = 1'b0;
   logic          rst;
   logic          req_valid, req_ready, req_burst;
   logic [4:0]    req_type;
   logic [AW-1:0] req_addr;
   logic [DW-1:0] req_wdata;
   logic          rsp_valid;
   logic [DW-1:0] rsp_data;
   logic          mem_en, mem_we;
   logic [AW-1:0] mem_addr;
   logic [DW-1:0] mem_wdata, mem_rdata;

   logic [DW-1:0] mem   [NW];
   logic [DW-1:0] shadow[NW];
   int total = 0, bad = 0;

   always #2.5 clk = ~clk;

   always_ff @(posedge clk) begin
      if (mem_en) begin
         if (mem_we) mem[mem_addr] <= mem_wdata;
         mem_rdata <= mem[mem_addr];
      end
   end

   atomic_rmw_unit #(
      .AW(AW), .DW(DW),
      .TT_WRITE(C_WR), .TT_READ(C_RD), .TT_SET(C_SET),
      .TT_CLR(C_CLR), .TT_INC(C_INC), .TT_DEC(C_DEC),
      .WIN_EN(1'b1), .WIN_BASE(4'hC), .WIN_MASK(4'hC), .WIN_OP(OP_INC),
      .SHARED_ADDER(1'b1)
   ) u_dut (.*);

   function automatic int exp_op(logic [4:0] t, logic b, logic [AW-1:0] a);
      if (b) return 0;
      if (t == C_SET) return 1;
      if (t == C_CLR) return 2;
      if (t == C_INC) return 3;
      if (t == C_DEC) return 4;
      if (t == C_RD && a[3:2] == 2'b11) return 3;
      return 0;
   endfunction

   function automatic logic [DW-1:0] apply(int op, logic [DW-1:0] v);
      case (op)
         1: return 8'hFF;
         2: return 8'h00;
         3: return v + 8'd1;
         4: return v - 8'd1;
         default: return v;
      endcase
   endfunction

   function automatic string tag_of(logic [4:0] t, logic b, logic [AW-1:0] a);
      if (t == C_WR) return "R1";
      if (b) return (t == C_RD) ? "R2" : "R8";
      if (t == C_RD) return (a[3:2] == 2'b11) ? "R9" : "R2";
      if (a[3:2] == 2'b11) return "R10";
      if (t == C_SET) return "R3";
      if (t == C_CLR) return "R4";
      if (t == C_INC) return "R5";
      return "R6";
   endfunction

   task automatic chk(bit ok, string tag, string what, int act, int expv);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, expv);
      end
   endtask

   task automatic run(logic [4:0] t, logic b, logic [AW-1:0] a, logic [DW-1:0] d);
      int    op;
      string tag;
      tag = tag_of(t, b, a);
      @(negedge clk);
      req_valid = 1'b1; req_type = t; req_burst = b; req_addr = a; req_wdata = d;
      while (!req_ready) @(negedge clk);
      @(posedge clk);
      @(negedge clk);
      req_valid = 1'b0;
      if (t == C_WR) begin
         chk(!rsp_valid, tag, "no response after write", int'(rsp_valid), 0);
         shadow[a] = d;
         chk(mem[a] == d, tag, "written word", int'(mem[a]), int'(d));
      end else begin
         op = exp_op(t, b, a);
         chk(rsp_valid && rsp_data == shadow[a], tag, "returned word",
             int'(rsp_data), int'(shadow[a]));
         if (op != 0) begin
            chk(!req_ready && mem_we && mem_addr == a, "R7", "write-back slot",
                int'(mem_addr), int'(a));
            shadow[a] = apply(op, shadow[a]);
            @(negedge clk);
         end
         chk(mem[a] == shadow[a], tag, "stored word after request",
             int'(mem[a]), int'(shadow[a]));
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      bad++; total++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      void'($urandom(32'd1234));
      rst = 1'b1; req_valid = 1'b0; req_type = C_RD; req_burst = 1'b0;
      req_addr = '0; req_wdata = '0;
      repeat (3) @(negedge clk);
      chk(req_ready && !rsp_valid && !mem_en, "R11", "reset outputs",
          {req_ready, rsp_valid, mem_en}, 3'b100);
      rst = 1'b0;
      @(negedge clk);
      chk(req_ready && !rsp_valid && !mem_en, "R11", "idle after reset",
          {req_ready, rsp_valid, mem_en}, 3'b100);

      for (int i = 0; i < NW; i++) run(C_WR, 1'b0, AW'(i), DW'(8'h10 + i));

      // directed corners
      run(C_RD,  1'b0, 4'h1, '0);          // R2 plain read
      run(C_SET, 1'b0, 4'h1, '0);          // R3
      run(C_CLR, 1'b0, 4'h2, '0);          // R4
      run(C_WR,  1'b0, 4'h3, 8'hFF);
      run(C_INC, 1'b0, 4'h3, '0);          // R5 wrap to 0
      run(C_DEC, 1'b0, 4'h3, '0);          // R6 wrap to FF
      run(C_SET, 1'b1, 4'h4, '0);          // R8 burst stays plain
      run(C_RD,  1'b1, 4'hD, '0);          // R8 burst in window stays plain
      run(C_RD,  1'b0, 4'hD, '0);          // R9 window increments
      run(C_CLR, 1'b0, 4'hE, '0);          // R10 code wins over window

      // R7: request held during write-back must wait
      @(negedge clk);
      req_valid = 1'b1; req_type = C_SET; req_burst = 1'b0; req_addr = 4'h5;
      @(posedge clk);
      @(negedge clk);
      req_type = C_WR; req_addr = 4'h6; req_wdata = 8'h55;
      chk(!req_ready && mem_we && mem_addr == 4'h5, "R7", "held request blocked",
          int'(mem_addr), 5);
      shadow[5] = 8'hFF;
      @(negedge clk);
      chk(req_ready && mem_we && mem_addr == 4'h6, "R7", "held request follows",
          int'(mem_addr), 6);
      @(posedge clk);
      @(negedge clk);
      req_valid = 1'b0;
      shadow[6] = 8'h55;
      chk(mem[5] == 8'hFF, "R7", "write-back landed", int'(mem[5]), 8'hFF);
      chk(mem[6] == 8'h55, "R7", "held write landed", int'(mem[6]), 8'h55);

      // constrained random mix
      for (int i = 0; i < 400; i++) begin
         logic [4:0] t;
         int k;
         k = $urandom_range(0, 6);
         case (k)
            0: t = C_WR;  1: t = C_RD;  2: t = C_SET; 3: t = C_CLR;
            4: t = C_INC; 5: t = C_DEC; default: t = C_RD;
         endcase
         run(t, ($urandom_range(0, 5) == 0), AW'($urandom_range(0, NW - 1)),
             DW'($urandom));
      end

      for (int i = 0; i < NW; i++)
         chk(mem[i] == shadow[i], "R2", "final image", int'(mem[i]), int'(shadow[i]));

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule